// File: doc/BRIEF.md
# Chip-Select Bus Cycle Timing Controller

This block sequences external bus cycles for one chip-select space. A requester presents read or write accesses through a valid/ready handshake. For each accepted access the block drives an active-high chip select, a one-cycle read or write strobe, and a done pulse. A 16-bit configuration register sets the spacing of the cycles. It can hold the bus idle for 0 to 3 cycles when a write comes right after a read. It can drop chip select for one cycle between accesses that follow each other. It can also widen chip select by one cycle on each side of the strobe.

The sequencer has four states. IDLE drives nothing. LEAD asserts chip select before the strobe. STROBE asserts chip select, the read or write strobe and done. TRAIL asserts chip select after the strobe. The transitions are:
- IDLE→LEAD on accept when widening is on, and IDLE→STROBE on accept when it is off.
- LEAD→STROBE always.
- STROBE→TRAIL when the access was accepted with widening.
- STROBE→LEAD/STROBE, or TRAIL→LEAD/STROBE, when the next access is accepted in the final active cycle.
- STROBE→IDLE or TRAIL→IDLE otherwise.

The final active cycle is STROBE without widening, or TRAIL. Idle cycles are counted from the end of that cycle. A requester that was already quiet for long enough waits no extra cycles.

Top module: `csbus_timer`

## Requirements
- R1: Only bits 9:8 (read-to-write idle count), bit 4 (back-to-back separation enable) and bit 0 (chip-select widening enable) of the configuration register take written values. Every other bit always reads 1, so a write of d reads back as d | 16'hFCEE.
- R2: After reset the register reads 16'hFFFF, chip select, both strobes and done are low, and ready is high while no request is pending.
- R3: The first access after reset waits no idle cycles. Its strobe comes 1 cycle after acceptance without widening, or 2 cycles after with widening.
- R4: With widening, chip select is high and neither strobe is high in the cycle before and in the cycle after each strobe.
- R5: A write accepted after a read waits at least the value of bits 9:8 in idle cycles (0, 1, 2 or 3) after the read ends, with chip select, read and write all low during those cycles.
- R6: With bit 4 set, any two consecutive accesses are separated by at least one cycle with chip select low. With bit 4 clear, and no read-to-write idle due, the next access can be accepted in the final active cycle of the previous one, so chip select stays high across both.
- R7: When a read-to-write idle count and the separation cycle both apply, the gap is the larger of the two, never their sum.
- R8: Idle cycles are counted from the last cycle of the previous access, including its trailing widening cycle. If the request came later than the required gap, it is accepted in the cycle it is presented.
- R9: Read and write are never high together. Read strobes read accesses, write strobes write accesses, and done is high exactly in the strobe cycle.
- R10: A register write made while an access is in progress leaves that access's widening unchanged. The new value applies from the next acceptance on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_ready | output | 1 | Block accepts the request this cycle |
| bus_cs | output | 1 | Chip select, active high |
| bus_rd | output | 1 | Read strobe, active high |
| bus_wr | output | 1 | Write strobe, active high |
| acc_done | output | 1 | One-cycle pulse at the strobe of each access |

## Verification
The bench builds the block with the default idle-field width of two bits. This brings the whole 0-to-3 idle range and the saturation of the idle counter at three within reach. It gives one worked case where the separation cycle and a one-cycle read-to-write idle would differ between a maximum and a sum. Random access mixes, requester delays and register writes made in the middle of accesses reach every ordering of read and write pairs, with widening both on and off.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

    localparam int REG_W    = 16;
    localparam int IW_LSB   = 8;
    localparam int CONS_BIT = 4;
    localparam int EXT_BIT  = 0;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_STROBE,
        ST_TRAIL
    } seq_state_t;

endpackage

// File: rtl/cbt_cfg_reg.sv
module cbt_cfg_reg
    import cbt_pkg::*;
#(
    parameter int GAP_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic [GAP_W-1:0] rw_idle,
    output logic             cons_en,
    output logic             ext_en
);

    localparam logic [REG_W-1:0] IW_MASK = REG_W'(((1 << GAP_W) - 1) << IW_LSB);
    localparam logic [REG_W-1:0] WMASK   = IW_MASK
                                         | REG_W'(1 << CONS_BIT)
                                         | REG_W'(1 << EXT_BIT);

    logic [REG_W-1:0] cfg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '1;
        end else if (we) begin
            cfg_q <= wdata | ~WMASK;
        end
    end

    always_comb begin
        rdata   = cfg_q;
        rw_idle = cfg_q[IW_LSB +: GAP_W];
        cons_en = cfg_q[CONS_BIT];
        ext_en  = cfg_q[EXT_BIT];
    end

    AST_CFG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(rdata)); // R1

endmodule

// File: rtl/cbt_gap_calc.sv
module cbt_gap_calc #(
    parameter int GAP_W = 2
) (
    input  logic             have_prev,
    input  logic             prev_wr,
    input  logic             next_wr,
    input  logic             cons_en,
    input  logic [GAP_W-1:0] rw_idle,
    input  logic [GAP_W-1:0] elapsed,
    output logic             gap_ok
);

    logic [GAP_W-1:0] cons_need;
    logic [GAP_W-1:0] rw_need;
    logic [GAP_W-1:0] need;

    always_comb begin
        cons_need = {{(GAP_W-1){1'b0}}, cons_en};
        rw_need   = (!prev_wr && next_wr) ? rw_idle : '0;
        if (!have_prev) begin
            need = '0;
        end else if (rw_need > cons_need) begin
            need = rw_need;
        end else begin
            need = cons_need;
        end
        gap_ok = (elapsed >= need);
    end

endmodule

// File: rtl/cbt_seq.sv
module cbt_seq
    import cbt_pkg::*;
#(
    parameter int GAP_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             ext_cfg,
    input  logic             gap_ok,
    output logic             req_ready,
    output logic             have_eff,
    output logic             prev_eff,
    output logic [GAP_W-1:0] elapsed,
    output logic             cs_o,
    output logic             rd_o,
    output logic             wr_o,
    output logic             done_o
);

    localparam logic [GAP_W-1:0] CNT_MAX = '1;

    seq_state_t       state, state_nx, start_st;
    logic             cur_wr_q;
    logic             ext_q;
    logic             have_prev_q;
    logic             prev_wr_q;
    logic [GAP_W-1:0] idle_cnt;
    logic             fin;
    logic             accept;

    always_comb begin
        fin       = (state == ST_TRAIL) || (state == ST_STROBE && !ext_q);
        req_ready = ((state == ST_IDLE) || fin) && gap_ok;
        accept    = req_valid && req_ready;
        have_eff  = fin || have_prev_q;
        prev_eff  = fin ? cur_wr_q : prev_wr_q;
        elapsed   = fin ? '0 : idle_cnt;
        start_st  = ext_cfg ? ST_LEAD : ST_STROBE;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   state_nx = accept ? start_st : ST_IDLE;
            ST_LEAD:   state_nx = ST_STROBE;
            ST_STROBE: begin
                if (ext_q) begin
                    state_nx = ST_TRAIL;
                end else begin
                    state_nx = accept ? start_st : ST_IDLE;
                end
            end
            ST_TRAIL:  state_nx = accept ? start_st : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_wr_q    <= 1'b0;
            ext_q       <= 1'b0;
            have_prev_q <= 1'b0;
            prev_wr_q   <= 1'b0;
            idle_cnt    <= '0;
        end else begin
            if (accept) begin
                cur_wr_q <= req_write;
                ext_q    <= ext_cfg;
            end
            if (fin) begin
                have_prev_q <= 1'b1;
                prev_wr_q   <= cur_wr_q;
            end
            if (accept) begin
                idle_cnt <= '0;
            end else if (fin) begin
                idle_cnt <= GAP_W'(1);
            end else if (state == ST_IDLE && idle_cnt != CNT_MAX) begin
                idle_cnt <= idle_cnt + GAP_W'(1);
            end
        end
    end

    always_comb begin
        cs_o   = 1'b0;
        rd_o   = 1'b0;
        wr_o   = 1'b0;
        done_o = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_LEAD: cs_o = 1'b1;
            ST_STROBE: begin
                cs_o   = 1'b1;
                rd_o   = !cur_wr_q;
                wr_o   = cur_wr_q;
                done_o = 1'b1;
            end
            ST_TRAIL: cs_o = 1'b1;
            default: ;
        endcase
    end

    AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_o && wr_o)); // R9
    AST_DONE_AT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (rd_o || wr_o)); // R9
    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_o || wr_o) |-> cs_o); // R4
    AST_LEAD_CS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_o || wr_o) && ext_q) |-> $past(cs_o)); // R4
    AST_TRAIL_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STROBE && ext_q) |=> (cs_o && !rd_o && !wr_o)); // R4
    AST_EXT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LEAD) |=> $stable(ext_q)); // R10

endmodule

// File: rtl/csbus_timer.sv
module csbus_timer
    import cbt_pkg::*;
#(
    parameter int GAP_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             req_valid,
    input  logic             req_write,
    output logic             req_ready,
    output logic             bus_cs,
    output logic             bus_rd,
    output logic             bus_wr,
    output logic             acc_done
);

    logic [GAP_W-1:0] rw_idle;
    logic             cons_en;
    logic             ext_en;
    logic             have_eff;
    logic             prev_eff;
    logic [GAP_W-1:0] elapsed;
    logic             gap_ok;

    cbt_cfg_reg #(.GAP_W(GAP_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .rw_idle (rw_idle),
        .cons_en (cons_en),
        .ext_en  (ext_en)
    );

    cbt_gap_calc #(.GAP_W(GAP_W)) u_gap (
        .have_prev (have_eff),
        .prev_wr   (prev_eff),
        .next_wr   (req_write),
        .cons_en   (cons_en),
        .rw_idle   (rw_idle),
        .elapsed   (elapsed),
        .gap_ok    (gap_ok)
    );

    cbt_seq #(.GAP_W(GAP_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .ext_cfg   (ext_en),
        .gap_ok    (gap_ok),
        .req_ready (req_ready),
        .have_eff  (have_eff),
        .prev_eff  (prev_eff),
        .elapsed   (elapsed),
        .cs_o      (bus_cs),
        .rd_o      (bus_rd),
        .wr_o      (bus_wr),
        .done_o    (acc_done)
    );

    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !bus_cs) |-> (!bus_rd && !bus_wr && !acc_done)); // R5

endmodule

// File: tb/csbus_timer_tb.sv
module csbus_timer_tb;

    localparam logic [15:0] RSV = 16'hFCEE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_ready;
    logic        bus_cs, bus_rd, bus_wr, acc_done;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    csbus_timer u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_write(req_write),
        .req_ready(req_ready), .bus_cs(bus_cs), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .acc_done(acc_done)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_need(input bit prev_wr, input bit wr, input logic [15:0] c);
        int rw_n;
        int cons_n;
        rw_n   = (!prev_wr && wr) ? int'(c[9:8]) : 0;
        cons_n = c[4] ? 1 : 0;
        return (rw_n > cons_n) ? rw_n : cons_n;
    endfunction

    function automatic string gap_tag(input bit prev_wr, input bit wr, input logic [15:0] c,
                                      input int v, input int fin_p, input int need);
        if (v > fin_p + need) return "R8";
        if (!prev_wr && wr && c[4] && c[9:8] != 2'd0) return "R7";
        if (!prev_wr && wr) return "R5";
        return "R6";
    endfunction

    logic [15:0] shadow = 16'hFFFF;
    bit first = 1'b1;
    bit prev_wr_b = 1'b0;
    int fin_prev = 0;
    int exp_cs = 0;
    int cs_seen = 0;
    bit mon_en = 1'b0;
    bit hung = 1'b0;
    int qa[$];
    int qe[$];
    bit qw[$];

    task automatic write_cfg(input logic [15:0] d);
        cfg_we = 1'b1;
        cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        shadow = d | RSV;
    endtask

    task automatic do_access(input bit wr, input int dly);
        int v, a, need, exp_a, e, guard;
        bit got;
        string tag;
        repeat (dly) @(posedge clk);
        #1;
        req_valid = 1'b1;
        req_write = wr;
        v = cyc;
        need  = first ? 0 : exp_need(prev_wr_b, wr, shadow);
        exp_a = first ? v : ((v > fin_prev + need) ? v : fin_prev + need);
        tag   = first ? "R3" : gap_tag(prev_wr_b, wr, shadow, v, fin_prev, need);
        got = 1'b0;
        guard = 0;
        a = 0;
        while (!got && guard < 40) begin
            @(negedge clk);
            if (req_ready) begin
                got = 1'b1;
                a = cyc;
            end else begin
                guard++;
            end
            @(posedge clk); #1;
        end
        req_valid = 1'b0;
        if (!got) begin
            hung = 1'b1;
            check(1'b0, tag, "request never accepted", guard, 0);
            return;
        end
        check(a == exp_a, tag, "acceptance cycle", a, exp_a);
        e = shadow[0] ? 1 : 0;
        qa.push_back(a);
        qe.push_back(e);
        qw.push_back(wr);
        fin_prev  = a + 1 + 2 * e;
        prev_wr_b = wr;
        first     = 1'b0;
        exp_cs   += 1 + 2 * e;
    endtask

    bit prev_cs = 1'b0;
    bit prev_stb = 1'b0;
    bit pend_trail = 1'b0;

    always @(negedge clk) begin
        if (mon_en) begin
            if (bus_cs) cs_seen++;
            if (pend_trail) begin
                check(bus_cs && !bus_rd && !bus_wr, "R4", "trailing widening cycle",
                      {bus_cs, bus_rd, bus_wr}, 3'b100);
                pend_trail = 1'b0;
            end
            if (bus_rd || bus_wr) begin
                if (qa.size() == 0) begin
                    check(1'b0, "R9", "strobe without accepted access", 1, 0);
                end else begin
                    int a_i, e_i;
                    bit w_i;
                    a_i = qa.pop_front();
                    e_i = qe.pop_front();
                    w_i = qw.pop_front();
                    check(bus_rd == !w_i && bus_wr == w_i && acc_done, "R9",
                          "strobe kind and done", {bus_rd, bus_wr, acc_done},
                          {!w_i, w_i, 1'b1});
                    check(cyc == a_i + 1 + e_i, "R3", "strobe cycle", cyc, a_i + 1 + e_i);
                    if (e_i == 1) begin
                        check(prev_cs && !prev_stb, "R4", "leading widening cycle",
                              {prev_cs, prev_stb}, 2'b10);
                        pend_trail = 1'b1;
                    end
                end
            end else begin
                check(!acc_done, "R9", "done outside strobe", acc_done, 0);
            end
            prev_cs  = bus_cs;
            prev_stb = bus_rd || bus_wr;
        end
    end

    initial begin
        #1200000;
        check(1'b0, "R2", "watchdog expired", cyc, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        check(cfg_rdata == 16'hFFFF, "R2", "register after reset", cfg_rdata, 16'hFFFF);
        check(!bus_cs && !bus_rd && !bus_wr && !acc_done, "R2", "bus outputs after reset",
              {bus_cs, bus_rd, bus_wr, acc_done}, 0);
        check(req_ready, "R2", "ready after reset", req_ready, 1);
        mon_en = 1'b1;
        @(posedge clk); #1;

        // R1 writable and reserved bits
        write_cfg(16'h0000);
        @(negedge clk);
        check(cfg_rdata == 16'hFCEE, "R1", "write zero", cfg_rdata, 16'hFCEE);
        @(posedge clk); #1;
        for (int i = 0; i < 6; i++) begin
            logic [15:0] d;
            d = 16'($urandom);
            write_cfg(d);
            @(negedge clk);
            check(cfg_rdata == (d | RSV), "R1", "random write readback", cfg_rdata, d | RSV);
            @(posedge clk); #1;
        end

        // R3 first access, then R6 continuous chip select with all spacing off
        write_cfg(16'h0000);
        do_access(1'b0, 0);
        do_access(1'b0, 0);
        do_access(1'b1, 0);
        do_access(1'b1, 0);
        do_access(1'b0, 0);

        // R5 read-to-write idle counts
        write_cfg(16'h0200);
        do_access(1'b0, 3);
        do_access(1'b1, 0);
        write_cfg(16'h0300);
        do_access(1'b0, 3);
        do_access(1'b1, 0);
        write_cfg(16'h0100);
        do_access(1'b0, 3);
        do_access(1'b1, 0);

        // R6 separation on, R7 maximum not sum
        write_cfg(16'h0010);
        do_access(1'b0, 3);
        do_access(1'b0, 0);
        do_access(1'b1, 0);
        do_access(1'b0, 0);
        write_cfg(16'h0110);
        do_access(1'b0, 3);
        do_access(1'b1, 0);
        write_cfg(16'h0310);
        do_access(1'b0, 3);
        do_access(1'b1, 0);

        // R8 late request, and counting from trailing widening cycle
        write_cfg(16'h0300);
        do_access(1'b0, 3);
        do_access(1'b1, 5);
        write_cfg(16'h0301);
        do_access(1'b0, 3);
        do_access(1'b1, 0);

        // R10 register change during an access
        write_cfg(16'h0001);
        do_access(1'b0, 3);
        write_cfg(16'h0000);
        do_access(1'b1, 0);
        write_cfg(16'h0001);
        do_access(1'b0, 0);
        write_cfg(16'h0300);
        do_access(1'b1, 0);

        // random mix
        for (int k = 0; k < 300 && !hung; k++) begin
            int dly;
            dly = ($urandom % 4 == 0) ? int'($urandom % 6) : 0;
            if ($urandom % 6 == 0) write_cfg(16'($urandom));
            do_access(1'($urandom), dly);
        end

        repeat (10) @(posedge clk);
        @(negedge clk);
        check(qa.size() == 0, "R9", "accesses without strobe", qa.size(), 0);
        check(cs_seen == exp_cs, "R6", "chip-select high cycles", cs_seen, exp_cs);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule